// File: doc/BRIEF.md
# I2C Master Bus State Monitor

This block follows a shared I2C bus from the point of view of one master. It samples the raw SCL and SDA pins through a two-stage synchronizer, detects start and stop conditions, and keeps a 2-bit bus state that says whether the bus condition is not yet known, free, held by this master, or held by another master. Its inputs also include strobes from the master's bit engine. From these it raises the arbitration-lost flag, records the acknowledge result of the last byte sent, and flags an SCL line held low for too long.

Software uses an 8-bit write port. Field positions are bus state in bits [1:0], arbitration-lost clear in bit 2, timeout clear in bit 3, the received-NACK bit in bit 4 (writes ignored), and master-on-bus clear in bit 5. A write to the address register is signalled on a strobe input. That strobe also clears the error flags, so a new transfer starts clean.

Top module: `i2c_bus_monitor`

## Requirements
- R1: The bus state is encoded 0 = unknown, 1 = idle, 2 = owner (this master holds the bus), 3 = busy (another master holds the bus). After reset the state is 0 and all flags and sync_busy are 0.
- R2: While enable is low, the bus state becomes unknown at the next clock edge. Bus events, strobes and the SCL timeout have no effect while enable is low.
- R3: From unknown, the state leaves only to idle, on a detected stop or on a forcing software write. A start seen while unknown leaves it unknown.
- R4: A reg_wr with reg_wdata[1:0] = 1 while enabled and unknown moves the state to idle and holds sync_busy high for SYNC_LEN cycles from the next edge. Any other value, or a write of 1 in any other state, changes neither the state nor sync_busy.
- R5: Start (SDA falls while SCL high) and stop (SDA rises while SCL high) are judged on synchronized pins. The state changes on the third clock edge after the raw pin change. A start gives owner if own_start is high at that edge and busy otherwise. A stop gives idle.
- R6: When bit_chk or start_chk is high while enabled and the synchronized SDA is low, arb_lost and mb_irq set at the next edge, and an idle or owner state moves to busy.
- R7: arb_lost clears on a write with bit 2 set, low_tout on bit 3, and mb_irq on bit 5. An addr_wr pulse clears all three. Writing 0 to those bits has no effect. A set in the same cycle wins over a clear.
- R8: On ack_strobe while enabled, rx_nack takes ack_val (0 = ACK, 1 = NACK). Software writes, including bit 4, never change it.
- R9: When the synchronized SCL has been low for TOUT_CYC consecutive enabled cycles, low_tout sets once. It does not set again until SCL has gone high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| enable | input | 1 | Master enable |
| scl_in | input | 1 | Raw SCL pin level |
| sda_in | input | 1 | Raw SDA pin level |
| own_start | input | 1 | High while the start on the bus is issued by this master |
| bit_chk | input | 1 | Strobe: SDA sampled during a high data bit or NACK bit this master sent |
| start_chk | input | 1 | Strobe: SDA sampled while this master generates a (repeated) start |
| ack_strobe | input | 1 | Strobe: acknowledge of the last byte sent was sampled |
| ack_val | input | 1 | Sampled acknowledge level, 1 = NACK |
| addr_wr | input | 1 | Strobe: address register written |
| reg_wr | input | 1 | Software write strobe |
| reg_wdata | input | 8 | Software write data |
| bus_state | output | 2 | Current bus state |
| arb_lost | output | 1 | Arbitration lost flag |
| rx_nack | output | 1 | Received NACK flag |
| low_tout | output | 1 | SCL low timeout flag |
| mb_irq | output | 1 | Master-on-bus interrupt flag |
| sync_busy | output | 1 | Forced bus-state update in progress |

## Verification
On every cycle the assertions check the following. The disabled state always becomes unknown. Unknown only ever exits to idle. Owner is entered only with own_start high. sync_busy only rises after a forcing write. arb_lost never rises without mb_irq. rx_nack holds without an acknowledge strobe. An address write leaves the error flags clear. The timeout rises only after SCL has been low. Some behaviour only the bench scenarios can show: the exact three-edge latency from pin to state, the busy/owner choice for foreign and own starts, the effect of write-one versus write-zero on each flag, the length of the sync_busy window, and that the timeout fires once after the exact count and stays cleared while SCL remains low.

// File: rtl/i2c_bmon_pkg.sv
package i2c_bmon_pkg;
  typedef enum logic [1:0] {
    BS_UNKNOWN = 2'd0,
    BS_IDLE    = 2'd1,
    BS_OWNER   = 2'd2,
    BS_BUSY    = 2'd3
  } bus_st_e;

  localparam int WDATA_W     = 8;
  localparam int F_STATE_LSB = 0;
  localparam int F_ARB_CLR   = 2;
  localparam int F_TOUT_CLR  = 3;
  localparam int F_NACK      = 4;
  localparam int F_MB_CLR    = 5;
endpackage

// File: rtl/i2c_bmon_sync.sv
module i2c_bmon_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic sda_s,
  output logic start_det,
  output logic stop_det
);
  localparam int LINES = 2;

  logic [LINES-1:0] pin_raw;
  logic [LINES-1:0] pin_sync;
  logic [LINES-1:0] pin_prev;

  assign pin_raw = {sda_in, scl_in};

  genvar g;
  for (g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;
    if (STAGES > 1) begin : g_multi
      assign chain_d = {chain_q[STAGES-2:0], pin_raw[g]};
    end else begin : g_single
      assign chain_d = pin_raw[g];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '1;
      else        chain_q <= chain_d;
    end
    assign pin_sync[g] = chain_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_prev <= '1;
    else        pin_prev <= pin_sync;
  end

  assign scl_s     = pin_sync[0];
  assign sda_s     = pin_sync[1];
  assign start_det = pin_sync[0] & pin_prev[0] & pin_prev[1] & ~pin_sync[1];
  assign stop_det  = pin_sync[0] & pin_prev[0] & ~pin_prev[1] & pin_sync[1];
endmodule

// File: rtl/i2c_bmon_tout.sv
module i2c_bmon_tout #(
  parameter int TOUT_CYC = 1200000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic scl_s,
  output logic tout_hit
);
  localparam int CNT_W = $clog2(TOUT_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(TOUT_CYC);
  localparam logic [CNT_W-1:0] CNT_FIRE = CNT_W'(TOUT_CYC - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             low_run;

  assign low_run = en & ~scl_s;

  always_comb begin
    cnt_d = cnt_q;
    if (!low_run)              cnt_d = '0;
    else if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tout_hit = low_run & (cnt_q == CNT_FIRE);
endmodule

// File: rtl/i2c_bmon_state.sv
module i2c_bmon_state
  import i2c_bmon_pkg::*;
#(
  parameter int SYNC_LEN = 2
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    en,
  input  logic    start_det,
  input  logic    stop_det,
  input  logic    own_start,
  input  logic    arb_ev,
  input  logic    force_req,
  output bus_st_e state,
  output logic    sync_busy
);
  localparam int SB_W = $clog2(SYNC_LEN + 1);

  bus_st_e        st_q, st_d;
  logic [SB_W-1:0] sb_q, sb_d;
  logic           force_ok;

  assign force_ok = en & force_req & (st_q == BS_UNKNOWN);

  always_comb begin
    st_d = st_q;
    if (!en)                                   st_d = BS_UNKNOWN;
    else if (stop_det)                         st_d = BS_IDLE;
    else if (arb_ev && st_q != BS_UNKNOWN)     st_d = BS_BUSY;
    else if (start_det && st_q != BS_UNKNOWN)  st_d = own_start ? BS_OWNER : BS_BUSY;
    else if (force_ok)                         st_d = BS_IDLE;
  end

  always_comb begin
    if (force_ok)        sb_d = SB_W'(SYNC_LEN);
    else if (sb_q != '0) sb_d = sb_q - 1'b1;
    else                 sb_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= BS_UNKNOWN;
      sb_q <= '0;
    end else begin
      st_q <= st_d;
      sb_q <= sb_d;
    end
  end

  assign state     = st_q;
  assign sync_busy = (sb_q != '0);
endmodule

// File: rtl/i2c_bus_monitor.sv
module i2c_bus_monitor
  import i2c_bmon_pkg::*;
#(
  parameter int TOUT_CYC    = 1200000,
  parameter int SYNC_LEN    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic               scl_in,
  input  logic               sda_in,
  input  logic               own_start,
  input  logic               bit_chk,
  input  logic               start_chk,
  input  logic               ack_strobe,
  input  logic               ack_val,
  input  logic               addr_wr,
  input  logic               reg_wr,
  input  logic [WDATA_W-1:0] reg_wdata,
  output logic [1:0]         bus_state,
  output logic               arb_lost,
  output logic               rx_nack,
  output logic               low_tout,
  output logic               mb_irq,
  output logic               sync_busy
);
  logic    scl_s, sda_s, start_det, stop_det, tout_hit;
  logic    arb_ev, force_req;
  logic    clr_arb, clr_tout, clr_mb;
  logic    arb_q, arb_d, tout_q, tout_d, mb_q, mb_d, nack_q, nack_d;
  bus_st_e state;

  i2c_bmon_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .scl_s(scl_s), .sda_s(sda_s), .start_det(start_det), .stop_det(stop_det)
  );

  i2c_bmon_tout #(.TOUT_CYC(TOUT_CYC)) u_tout (
    .clk(clk), .rst_n(rst_n), .en(enable), .scl_s(scl_s), .tout_hit(tout_hit)
  );

  assign arb_ev    = enable & (bit_chk | start_chk) & ~sda_s;
  assign force_req = reg_wr & (reg_wdata[F_STATE_LSB +: 2] == BS_IDLE);
  assign clr_arb   = addr_wr | (reg_wr & reg_wdata[F_ARB_CLR]);
  assign clr_tout  = addr_wr | (reg_wr & reg_wdata[F_TOUT_CLR]);
  assign clr_mb    = addr_wr | (reg_wr & reg_wdata[F_MB_CLR]);

  i2c_bmon_state #(.SYNC_LEN(SYNC_LEN)) u_state (
    .clk(clk), .rst_n(rst_n), .en(enable), .start_det(start_det),
    .stop_det(stop_det), .own_start(own_start), .arb_ev(arb_ev),
    .force_req(force_req), .state(state), .sync_busy(sync_busy)
  );

  always_comb begin
    arb_d  = arb_q;
    tout_d = tout_q;
    mb_d   = mb_q;
    nack_d = nack_q;
    if (arb_ev)        arb_d = 1'b1;
    else if (clr_arb)  arb_d = 1'b0;
    if (arb_ev)        mb_d = 1'b1;
    else if (clr_mb)   mb_d = 1'b0;
    if (tout_hit)      tout_d = 1'b1;
    else if (clr_tout) tout_d = 1'b0;
    if (enable && ack_strobe) nack_d = ack_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arb_q  <= 1'b0;
      tout_q <= 1'b0;
      mb_q   <= 1'b0;
      nack_q <= 1'b0;
    end else begin
      arb_q  <= arb_d;
      tout_q <= tout_d;
      mb_q   <= mb_d;
      nack_q <= nack_d;
    end
  end

  assign bus_state = state;
  assign arb_lost  = arb_q;
  assign low_tout  = tout_q;
  assign mb_irq    = mb_q;
  assign rx_nack   = nack_q;
endmodule

// File: rtl/i2c_bmon_checker.sv
module i2c_bmon_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       enable,
  input logic       own_start,
  input logic       bit_chk,
  input logic       start_chk,
  input logic       ack_strobe,
  input logic       addr_wr,
  input logic       reg_wr,
  input logic [7:0] reg_wdata,
  input logic [1:0] bus_state,
  input logic       arb_lost,
  input logic       rx_nack,
  input logic       low_tout,
  input logic       mb_irq,
  input logic       sync_busy,
  input logic       scl_s
);
  AST_DISABLED_UNKNOWN: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> bus_state == 2'd0); // R2

  AST_UNKNOWN_EXIT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_state == 2'd0 |=> (bus_state == 2'd0 || bus_state == 2'd1)); // R3

  AST_SYNC_BUSY_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_busy) |-> $past(reg_wr && reg_wdata[1:0] == 2'd1)); // R4

  AST_OWNER_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    bus_state != 2'd2 |=> (bus_state != 2'd2 || $past(own_start))); // R5

  AST_ARB_RAISES_MB: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(arb_lost) |-> mb_irq); // R6

  AST_ADDR_CLEARS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_wr && !bit_chk && !start_chk) |=> (!arb_lost && !mb_irq)); // R7

  AST_NACK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(enable && ack_strobe) |=> $stable(rx_nack)); // R8

  AST_TOUT_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(low_tout) |-> $past(enable && !scl_s)); // R9
endmodule

bind i2c_bus_monitor i2c_bmon_checker u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .own_start(own_start),
  .bit_chk(bit_chk), .start_chk(start_chk), .ack_strobe(ack_strobe),
  .addr_wr(addr_wr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
  .bus_state(bus_state), .arb_lost(arb_lost), .rx_nack(rx_nack),
  .low_tout(low_tout), .mb_irq(mb_irq), .sync_busy(sync_busy), .scl_s(scl_s)
);

// File: tb/i2c_bus_monitor_tb_top.sv
module i2c_bus_monitor_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TOUT       = 20;
  localparam int SBLEN      = 2;
  localparam int WD_CYCLES  = 50000;

  logic       clk = 1'b0;
  logic       rst_n, enable, scl_in, sda_in, own_start, bit_chk, start_chk;
  logic       ack_strobe, ack_val, addr_wr, reg_wr;
  logic [7:0] reg_wdata;
  logic [1:0] bus_state;
  logic       arb_lost, rx_nack, low_tout, mb_irq, sync_busy;

  int    vectors = 0;
  int    fails   = 0;
  string cur_req = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_bus_monitor #(.TOUT_CYC(TOUT), .SYNC_LEN(SBLEN), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .scl_in(scl_in), .sda_in(sda_in),
    .own_start(own_start), .bit_chk(bit_chk), .start_chk(start_chk),
    .ack_strobe(ack_strobe), .ack_val(ack_val), .addr_wr(addr_wr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .bus_state(bus_state),
    .arb_lost(arb_lost), .rx_nack(rx_nack), .low_tout(low_tout),
    .mb_irq(mb_irq), .sync_busy(sync_busy)
  );

  // Behavioural reference model
  bit q_scl[$];
  bit q_sda[$];
  int m_st, m_arb, m_nack, m_tout, m_mb, m_sbcnt, m_low;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_scl = '{1'b1, 1'b1, 1'b1};
      q_sda = '{1'b1, 1'b1, 1'b1};
      m_st = 0; m_arb = 0; m_nack = 0; m_tout = 0; m_mb = 0; m_sbcnt = 0; m_low = 0;
    end else begin
      bit s_scl, d_scl, s_sda, d_sda, st_ev, sp_ev, arb, hit, frc;
      int ns;
      s_scl = q_scl[1]; d_scl = q_scl[2];
      s_sda = q_sda[1]; d_sda = q_sda[2];
      st_ev = s_scl && d_scl && d_sda && !s_sda;
      sp_ev = s_scl && d_scl && !d_sda && s_sda;
      arb   = enable && (bit_chk || start_chk) && !s_sda;
      hit   = enable && !s_scl && (m_low == TOUT - 1);
      frc   = enable && reg_wr && (reg_wdata[1:0] == 2'd1) && (m_st == 0);
      ns = m_st;
      if (!enable)                 ns = 0;
      else if (sp_ev)              ns = 1;
      else if (arb && m_st != 0)   ns = 3;
      else if (st_ev && m_st != 0) ns = own_start ? 2 : 3;
      else if (frc)                ns = 1;
      if (frc)              m_sbcnt = SBLEN;
      else if (m_sbcnt > 0) m_sbcnt = m_sbcnt - 1;
      if (arb) m_arb = 1; else if (addr_wr || (reg_wr && reg_wdata[2])) m_arb = 0;
      if (arb) m_mb  = 1; else if (addr_wr || (reg_wr && reg_wdata[5])) m_mb  = 0;
      if (hit) m_tout = 1; else if (addr_wr || (reg_wr && reg_wdata[3])) m_tout = 0;
      if (enable && ack_strobe) m_nack = ack_val;
      if (!enable || s_scl) m_low = 0;
      else if (m_low < TOUT) m_low = m_low + 1;
      m_st = ns;
      q_scl.push_front(scl_in); void'(q_scl.pop_back());
      q_sda.push_front(sda_in); void'(q_sda.pop_back());
    end
  end

  task automatic cmp(string nm, int act, int exp);
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual %0d expected %0d", cur_req, nm, act, exp);
    end
  endtask

  task automatic compare();
    vectors++;
    cmp("bus_state", int'(bus_state), m_st);
    cmp("arb_lost",  int'(arb_lost),  m_arb);
    cmp("rx_nack",   int'(rx_nack),   m_nack);
    cmp("low_tout",  int'(low_tout),  m_tout);
    cmp("mb_irq",    int'(mb_irq),    m_mb);
    cmp("sync_busy", int'(sync_busy), (m_sbcnt > 0) ? 1 : 0);
  endtask

  // Directed check against a value fixed by the requirements
  task automatic chk(string req, string nm, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual %0d expected %0d", req, nm, act, exp);
    end
  endtask

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
      compare();
    end
  endtask

  task automatic wr(logic [7:0] d);
    reg_wr = 1'b1; reg_wdata = d;
    step();
    reg_wr = 1'b0; reg_wdata = 8'h00;
  endtask

  task automatic bus_start(logic own);
    own_start = own;
    scl_in = 1'b1; sda_in = 1'b1; step(4);
    sda_in = 1'b0; step(4);
    own_start = 1'b0;
    scl_in = 1'b0; step(2);
  endtask

  task automatic bus_stop();
    scl_in = 1'b0; sda_in = 1'b0; step(2);
    scl_in = 1'b1; step(4);
    sda_in = 1'b1; step(4);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual 1 expected 0");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; enable = 1'b0; scl_in = 1'b1; sda_in = 1'b1;
    own_start = 1'b0; bit_chk = 1'b0; start_chk = 1'b0;
    ack_strobe = 1'b0; ack_val = 1'b0; addr_wr = 1'b0;
    reg_wr = 1'b0; reg_wdata = 8'h00;
    step(3);
    rst_n = 1'b1;
    step(2);
    cur_req = "R1";
    chk("R1", "bus_state", int'(bus_state), 0);
    chk("R1", "flags", int'({arb_lost, rx_nack, low_tout, mb_irq, sync_busy}), 0);

    // R3: enabled, a start while unknown is ignored; a stop leads to idle
    cur_req = "R3";
    enable = 1'b1; step(3);
    bus_start(1'b0);
    chk("R3", "bus_state after start in unknown", int'(bus_state), 0);
    scl_in = 1'b0; sda_in = 1'b0; step(2);
    scl_in = 1'b1; step(4);
    sda_in = 1'b1; step(2);
    chk("R5", "state two edges after stop", int'(bus_state), 0);
    step(1);
    chk("R3", "bus_state three edges after stop", int'(bus_state), 1);
    step(2);

    // R2: disable returns to unknown, strobes ignored
    cur_req = "R2";
    enable = 1'b0; step(1);
    chk("R2", "bus_state disabled", int'(bus_state), 0);
    ack_strobe = 1'b1; ack_val = 1'b1; bit_chk = 1'b1; sda_in = 1'b0; step(4);
    ack_strobe = 1'b0; bit_chk = 1'b0; sda_in = 1'b1; step(3);
    chk("R2", "flags untouched while disabled", int'({arb_lost, rx_nack, mb_irq}), 0);
    enable = 1'b1; step(1);

    // R4: only value 1 forces idle
    cur_req = "R4";
    wr(8'h02);
    chk("R4", "write 2 ignored", int'(bus_state), 0);
    chk("R4", "sync_busy after ignored write", int'(sync_busy), 0);
    wr(8'h03); step(1);
    wr(8'h01);
    chk("R4", "forced idle", int'(bus_state), 1);
    chk("R4", "sync_busy first cycle", int'(sync_busy), 1);
    step(1);
    chk("R4", "sync_busy second cycle", int'(sync_busy), 1);
    step(1);
    chk("R4", "sync_busy ended", int'(sync_busy), 0);
    wr(8'h01);
    chk("R4", "no sync_busy when already idle", int'(sync_busy), 0);
    step(2);

    // R5: own start -> owner, stop -> idle, foreign start -> busy
    cur_req = "R5";
    bus_start(1'b1);
    chk("R5", "own start gives owner", int'(bus_state), 2);
    bus_stop();
    chk("R5", "stop gives idle", int'(bus_state), 1);
    bus_start(1'b0);
    chk("R5", "foreign start gives busy", int'(bus_state), 3);
    bus_stop();
    chk("R5", "stop from busy gives idle", int'(bus_state), 1);

    // R6: arbitration lost on a high bit
    cur_req = "R6";
    bus_start(1'b1);
    scl_in = 1'b0; sda_in = 1'b0; step(3);
    scl_in = 1'b1; step(3);
    bit_chk = 1'b1; step(1); bit_chk = 1'b0;
    chk("R6", "arb_lost", int'(arb_lost), 1);
    chk("R6", "mb_irq", int'(mb_irq), 1);
    chk("R6", "owner to busy", int'(bus_state), 3);

    // R7: write-zero ignored, write-one clears each flag separately
    cur_req = "R7";
    wr(8'h00);
    chk("R7", "write zero keeps arb_lost", int'(arb_lost), 1);
    wr(8'h04);
    chk("R7", "bit2 clears arb_lost", int'(arb_lost), 0);
    chk("R7", "bit2 leaves mb_irq", int'(mb_irq), 1);
    wr(8'h20);
    chk("R7", "bit5 clears mb_irq", int'(mb_irq), 0);
    start_chk = 1'b1; step(1); start_chk = 1'b0;
    chk("R6", "start check sets arb_lost", int'(arb_lost), 1);
    addr_wr = 1'b1; step(1); addr_wr = 1'b0;
    chk("R7", "addr write clears arb_lost", int'(arb_lost), 0);
    chk("R7", "addr write clears mb_irq", int'(mb_irq), 0);
    bit_chk = 1'b1; reg_wr = 1'b1; reg_wdata = 8'h24; step(1);
    bit_chk = 1'b0; reg_wr = 1'b0; reg_wdata = 8'h00;
    chk("R7", "set wins over clear", int'(arb_lost), 1);
    addr_wr = 1'b1; step(1); addr_wr = 1'b0;
    bus_stop();

    // R8: acknowledge capture, writes ignored
    cur_req = "R8";
    ack_strobe = 1'b1; ack_val = 1'b1; step(1); ack_strobe = 1'b0; ack_val = 1'b0;
    chk("R8", "NACK captured", int'(rx_nack), 1);
    wr(8'h10); wr(8'h00);
    chk("R8", "write does not change rx_nack", int'(rx_nack), 1);
    ack_strobe = 1'b1; ack_val = 1'b0; step(1); ack_strobe = 1'b0;
    chk("R8", "ACK captured", int'(rx_nack), 0);
    wr(8'h10);
    chk("R8", "write one does not set rx_nack", int'(rx_nack), 0);

    // R9: SCL low timeout
    cur_req = "R9";
    scl_in = 1'b0; step(TOUT);
    chk("R9", "not yet timed out", int'(low_tout), 0);
    step(4);
    chk("R9", "timed out", int'(low_tout), 1);
    wr(8'h08);
    chk("R9", "bit3 clears low_tout", int'(low_tout), 0);
    step(10);
    chk("R9", "no second timeout while still low", int'(low_tout), 0);
    scl_in = 1'b1; step(4);
    scl_in = 1'b0; step(TOUT + 4);
    chk("R9", "timeout after new low period", int'(low_tout), 1);
    addr_wr = 1'b1; step(1); addr_wr = 1'b0;
    chk("R7", "addr write clears low_tout", int'(low_tout), 0);
    scl_in = 1'b1; step(4);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule